// File: doc/BRIEF.md
# Chained-Write Ultra Fast-mode Serial Sequencer

This block is a transmit-only serial engine for the Ultra Fast-mode two-wire bus. Its clock and data outputs are push-pull, so nothing is ever sampled back from the line. One start pulse makes the engine walk slot 0 up to a chosen last slot without further host help. Each slot is one write transaction. The slot takes a 7-bit target address from an address table and a byte count from a count table. Its payload is the next run of bytes in a shared payload buffer. The buffer holds payload only: slots are packed back to back, so ten targets at 26 bytes each use 260 buffer bytes. The first frame opens with a START, each later frame opens with a repeated START, and one STOP closes the whole pass.

After a pass the engine can replay the stored sequence by itself. The next pass is paced either by an internal interval counter or by rising edges of an external trigger. The engine writes a status code for every slot and keeps three sticky pending flags behind a mask, which together drive one interrupt line. The bit rate is set by a one-cycle enable pulse from outside the block. Each line step takes exactly one pulse. Inside the block, the sequencer hands START, byte, repeated-START and STOP commands to the line serializer over a valid/ready link. The sequencer holds valid and the command steady until the serializer is idle and takes it. That back-pressure is the only flow control: the tables and the buffer are written through a plain port with no ready, and a write offered while a pass is running is dropped.

Top module: `ufm_seq_tx`

## Requirements
- R1: After reset, and whenever no pass is running, `scl` and `sda` are both high, `busy` is low and `irq` is low until a pending flag is set.
- R2: Every frame is a START (sda falls while scl is high), then the byte {address[6:0], 1'b0}, then the payload bytes. Each byte goes out MSB first, one bit per high phase of scl. A ninth clock follows each byte with sda held high.
- R3: Within one pass, consecutive sent frames are separated by a repeated START, and exactly one STOP (sda rises while scl is high) follows the last sent frame.
- R4: Slots 0 to `last_slot` are sent in order. Each slot with count N sends the next N bytes of the payload buffer, and the buffer is read from address 0 onward with no gaps.
- R5: A slot whose count is zero sends nothing, has its status set to code 2, and sets pending bit 1 (configuration error). If every slot is zero, no START or STOP appears on the line.
- R6: A slot that is sent gets status code 1. At the end of each pass, pending bit 0 (pass done) is set. Code 0 means the slot has not been processed since the last reset.
- R7: `irq` is high exactly when (`irq_pend` & ~`irq_mask`) is non-zero. A pulse on `irq_ack` clears all pending bits, unless a bit is being set in the same cycle, in which case the set wins.
- R8: With `loop_en` high and `loop_trig` low, the next pass starts after `busy` has stayed low for exactly `interval`+1 clock cycles.
- R9: With `loop_en` and `loop_trig` high, a finished pass waits until a rising edge of `trig_in`, and only that edge starts the next pass. Dropping `loop_en` returns the engine to idle once the pass in flight has ended.
- R10: A rising edge of `trig_in` while a pass is running in trigger loop mode sets pending bit 2 (overrun).
- R11: Writes to the tables or the buffer while `busy` is high are ignored. Writes use `tbl_sel` 0 for the address table, 1 for the count table and 2 for the buffer.
- R12: `soft_rst` stops the engine on the next clock edge. After that edge both outputs are high, `busy` is low, and all pending bits and slot status codes are cleared.
- R13: `scl` and `sda` change only on cycles where `bit_en` is high (a soft reset excepted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous engine reset |
| bit_en | input | 1 | One pulse per line step |
| start | input | 1 | Starts a pass when the engine is idle |
| last_slot | input | SLOT_W | Index of the final slot of the sequence |
| loop_en | input | 1 | Replay the sequence after each pass |
| loop_trig | input | 1 | 1: pace replays by trigger, 0: by interval |
| interval | input | INT_W | Idle cycles between replays, minus one |
| trig_in | input | 1 | External trigger, asynchronous |
| tbl_we | input | 1 | Table or buffer write strobe |
| tbl_sel | input | 2 | Write target: 0 address, 1 count, 2 buffer |
| tbl_addr | input | BUF_AW | Slot index or buffer address |
| tbl_wdata | input | 8 | Write data |
| st_slot | input | SLOT_W | Slot whose status is read out |
| st_code | output | 2 | Status of `st_slot` |
| irq_mask | input | 3 | Per-flag interrupt mask |
| irq_ack | input | 1 | Clears the pending flags |
| busy | output | 1 | A pass is running |
| irq_pend | output | 3 | Pending flags: done, config error, overrun |
| irq | output | 1 | Interrupt request |
| scl | output | 1 | Push-pull serial clock |
| sda | output | 1 | Push-pull serial data |

## Verification
The bench decodes the line itself, watching for START and STOP edges and for the bit captured on each scl rise. It compares the result with a frame list built from a bench model of the tables. A design that emitted a STOP between frames, packed the buffer wrongly or fetched the wrong slot would give a different frame list. An engine that sent frames for zero-count slots, or opened the line for an all-zero sequence, would show up as extra frames or a stray START. The bench also checks the pacing corner cases: it counts the exact idle gap in timer mode, looks for a pass that starts without a trigger edge, and sends a trigger edge in the middle of a pass. A write made during a pass is checked by replaying the sequence, where a leaked write would change the payload on the line. A soft reset in the middle of a frame must leave both lines high.

// File: rtl/ufm_pkg.sv
package ufm_pkg;
  typedef enum logic [1:0] {K_START, K_BYTE, K_RSTART, K_STOP} ser_kind_e;
  typedef enum logic [1:0] {E_IDLE, E_RUN, E_WAIT} eng_st_e;
  typedef enum logic [2:0] {P_SLOT, P_OPEN, P_ADDR, P_DATA, P_NEXT, P_CLOSE, P_DRAIN} ph_e;
  localparam logic [1:0] ST_NONE = 2'd0;
  localparam logic [1:0] ST_SENT = 2'd1;
  localparam logic [1:0] ST_CFG  = 2'd2;
  localparam int PB_DONE = 0;
  localparam int PB_CFG  = 1;
  localparam int PB_OVR  = 2;
endpackage

// File: rtl/ufm_bit_tx.sv
module ufm_bit_tx
  import ufm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       bit_en,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  ser_kind_e  cmd_kind,
  input  logic [7:0] cmd_data,
  output logic       scl,
  output logic       sda
);
  logic       active;
  ser_kind_e  kind_q;
  logic [7:0] shreg;
  logic [4:0] step;

  assign cmd_ready = !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; kind_q <= K_START; shreg <= '0; step <= '0;
      scl <= 1'b1; sda <= 1'b1;
    end else if (srst) begin
      active <= 1'b0; step <= '0; scl <= 1'b1; sda <= 1'b1;
    end else if (!active) begin
      if (cmd_valid) begin
        active <= 1'b1; kind_q <= cmd_kind; shreg <= cmd_data; step <= '0;
      end
    end else if (bit_en) begin
      step <= step + 5'd1;
      unique case (kind_q)
        K_START: begin
          sda <= 1'b0; active <= 1'b0;
        end
        K_BYTE: begin
          if (!step[0]) begin
            scl <= 1'b0; sda <= shreg[7];
          end else begin
            scl <= 1'b1; shreg <= {shreg[6:0], 1'b1};
            if (step == 5'd17) active <= 1'b0;
          end
        end
        K_RSTART: begin
          if (step == 5'd0) begin scl <= 1'b0; sda <= 1'b1; end
          else if (step == 5'd1) scl <= 1'b1;
          else begin sda <= 1'b0; active <= 1'b0; end
        end
        K_STOP: begin
          if (step == 5'd0) begin scl <= 1'b0; sda <= 1'b0; end
          else if (step == 5'd1) scl <= 1'b1;
          else begin sda <= 1'b1; active <= 1'b0; end
        end
        default: active <= 1'b0;
      endcase
    end
  end

  // R13
  line_step_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !srst) |=> ($stable(scl) && $stable(sda)));

  // R2
  cmd_taken_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
endmodule

// File: rtl/ufm_seq_store.sv
module ufm_seq_store #(
  parameter int NSLOT     = 64,
  parameter int BUF_DEPTH = 512,
  parameter int CNT_W     = 8,
  parameter int SLOT_W    = $clog2(NSLOT),
  parameter int BUF_AW    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [BUF_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [6:0]        slv_addr,
  output logic [CNT_W-1:0]  slv_cnt,
  input  logic [BUF_AW-1:0] rd_ptr,
  output logic [7:0]        rd_byte,
  input  logic              st_we,
  input  logic [SLOT_W-1:0] st_wslot,
  input  logic [1:0]        st_wcode,
  input  logic [SLOT_W-1:0] st_rslot,
  output logic [1:0]        st_rcode
);
  logic [6:0]       adr_tab [NSLOT];
  logic [CNT_W-1:0] cnt_tab [NSLOT];
  logic [7:0]       pay_mem [BUF_DEPTH];
  logic [1:0]       st_tab  [NSLOT];

  wire [SLOT_W-1:0] wslot = wr_addr[SLOT_W-1:0];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_sel == 2'd0) adr_tab[wslot] <= wr_data[6:0];
      if (wr_sel == 2'd1) cnt_tab[wslot] <= wr_data[CNT_W-1:0];
      if (wr_sel == 2'd2) pay_mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) st_tab[i] <= 2'd0;
    end else if (srst) begin
      for (int i = 0; i < NSLOT; i++) st_tab[i] <= 2'd0;
    end else if (st_we) begin
      st_tab[st_wslot] <= st_wcode;
    end
  end

  assign slv_addr = adr_tab[rd_slot];
  assign slv_cnt  = cnt_tab[rd_slot];
  assign rd_byte  = pay_mem[rd_ptr];
  assign st_rcode = st_tab[st_rslot];
endmodule

// File: rtl/ufm_pace.sv
module ufm_pace #(
  parameter int INT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             trig_in,
  input  logic             wait_en,
  input  logic [INT_W-1:0] interval,
  output logic             trig_rise,
  output logic             tmr_done
);
  logic [2:0]       sync_q;
  logic [INT_W-1:0] tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0; tmr <= '0;
    end else if (srst) begin
      sync_q <= {sync_q[1:0], trig_in}; tmr <= '0;
    end else begin
      sync_q <= {sync_q[1:0], trig_in};
      if (!wait_en) tmr <= interval;
      else if (tmr != '0) tmr <= tmr - 1'b1;
    end
  end

  assign trig_rise = sync_q[1] && !sync_q[2];
  assign tmr_done  = wait_en && (tmr == '0);
endmodule

// File: rtl/ufm_seq_tx.sv
module ufm_seq_tx
  import ufm_pkg::*;
#(
  parameter int NSLOT     = 64,
  parameter int BUF_DEPTH = 512,
  parameter int CNT_W     = 8,
  parameter int INT_W     = 16,
  parameter int SLOT_W    = $clog2(NSLOT),
  parameter int BUF_AW    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              bit_en,
  input  logic              start,
  input  logic [SLOT_W-1:0] last_slot,
  input  logic              loop_en,
  input  logic              loop_trig,
  input  logic [INT_W-1:0]  interval,
  input  logic              trig_in,
  input  logic              tbl_we,
  input  logic [1:0]        tbl_sel,
  input  logic [BUF_AW-1:0] tbl_addr,
  input  logic [7:0]        tbl_wdata,
  input  logic [SLOT_W-1:0] st_slot,
  output logic [1:0]        st_code,
  input  logic [2:0]        irq_mask,
  input  logic              irq_ack,
  output logic              busy,
  output logic [2:0]        irq_pend,
  output logic              irq,
  output logic              scl,
  output logic              sda
);
  eng_st_e           st;
  ph_e               ph;
  logic [SLOT_W-1:0] idx;
  logic [BUF_AW-1:0] ptr;
  logic [CNT_W-1:0]  remain;
  logic              line_open;
  logic [2:0]        pend;

  logic [6:0]       slv_addr;
  logic [CNT_W-1:0] slv_cnt;
  logic [7:0]       rd_byte;
  logic             cmd_valid, cmd_ready, fire;
  ser_kind_e        cmd_kind;
  logic [7:0]       cmd_data;
  logic             trig_rise, tmr_done;
  logic             st_we;
  logic [1:0]       st_wcode;
  logic [2:0]       set_vec;
  logic             running, zero_slot, finish, rerun;

  assign running   = (st == E_RUN);
  assign zero_slot = running && (ph == P_SLOT) && (slv_cnt == '0);
  assign fire      = cmd_valid && cmd_ready;
  assign finish    = running && (((ph == P_CLOSE) && !line_open) ||
                                 ((ph == P_DRAIN) && cmd_ready));
  assign rerun     = loop_trig ? trig_rise : tmr_done;

  always_comb begin
    cmd_valid = 1'b0; cmd_kind = K_BYTE; cmd_data = rd_byte;
    if (running) begin
      unique case (ph)
        P_OPEN:  begin cmd_valid = 1'b1; cmd_kind = line_open ? K_RSTART : K_START; end
        P_ADDR:  begin cmd_valid = 1'b1; cmd_data = {slv_addr, 1'b0}; end
        P_DATA:  cmd_valid = 1'b1;
        P_CLOSE: begin cmd_valid = line_open; cmd_kind = K_STOP; end
        default: cmd_valid = 1'b0;
      endcase
    end
  end

  assign st_we    = zero_slot || (running && (ph == P_DATA) && fire && (remain == 1));
  assign st_wcode = zero_slot ? ST_CFG : ST_SENT;

  always_comb begin
    set_vec = '0;
    set_vec[PB_DONE] = finish;
    set_vec[PB_CFG]  = zero_slot;
    set_vec[PB_OVR]  = running && loop_en && loop_trig && trig_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= E_IDLE; ph <= P_SLOT; idx <= '0; ptr <= '0; remain <= '0;
      line_open <= 1'b0; pend <= '0;
    end else if (soft_rst) begin
      st <= E_IDLE; ph <= P_SLOT; idx <= '0; ptr <= '0; remain <= '0;
      line_open <= 1'b0; pend <= '0;
    end else begin
      pend <= (pend & ~{3{irq_ack}}) | set_vec;
      unique case (st)
        E_IDLE: if (start) begin
          st <= E_RUN; ph <= P_SLOT; idx <= '0; ptr <= '0; line_open <= 1'b0;
        end
        E_WAIT: begin
          if (!loop_en) st <= E_IDLE;
          else if (rerun) begin
            st <= E_RUN; ph <= P_SLOT; idx <= '0; ptr <= '0; line_open <= 1'b0;
          end
        end
        default: begin
          if (finish) st <= loop_en ? E_WAIT : E_IDLE;
          unique case (ph)
            P_SLOT: begin
              remain <= slv_cnt;
              ph <= (slv_cnt == '0) ? P_NEXT : P_OPEN;
            end
            P_OPEN: if (fire) begin line_open <= 1'b1; ph <= P_ADDR; end
            P_ADDR: if (fire) ph <= P_DATA;
            P_DATA: if (fire) begin
              ptr <= ptr + 1'b1;
              remain <= remain - 1'b1;
              if (remain == 1) ph <= P_NEXT;
            end
            P_NEXT: begin
              if (idx == last_slot) ph <= P_CLOSE;
              else begin idx <= idx + 1'b1; ph <= P_SLOT; end
            end
            P_CLOSE: if (fire) ph <= P_DRAIN;
            default: ;
          endcase
        end
      endcase
    end
  end

  ufm_seq_store #(.NSLOT(NSLOT), .BUF_DEPTH(BUF_DEPTH), .CNT_W(CNT_W),
                  .SLOT_W(SLOT_W), .BUF_AW(BUF_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .srst(soft_rst),
    .wr_en(tbl_we && !running), .wr_sel(tbl_sel), .wr_addr(tbl_addr), .wr_data(tbl_wdata),
    .rd_slot(idx), .slv_addr(slv_addr), .slv_cnt(slv_cnt),
    .rd_ptr(ptr), .rd_byte(rd_byte),
    .st_we(st_we), .st_wslot(idx), .st_wcode(st_wcode),
    .st_rslot(st_slot), .st_rcode(st_code));

  ufm_pace #(.INT_W(INT_W)) u_pace (
    .clk(clk), .rst_n(rst_n), .srst(soft_rst), .trig_in(trig_in),
    .wait_en(st == E_WAIT), .interval(interval),
    .trig_rise(trig_rise), .tmr_done(tmr_done));

  ufm_bit_tx u_line (
    .clk(clk), .rst_n(rst_n), .srst(soft_rst), .bit_en(bit_en),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_data(cmd_data),
    .scl(scl), .sda(sda));

  assign busy     = running;
  assign irq_pend = pend;
  assign irq      = |(pend & ~irq_mask);

  // R1
  idle_lines_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (scl && sda));

  // R5
  zero_count_flag_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    zero_slot |=> pend[PB_CFG]);

  // R10
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (running && loop_en && loop_trig && trig_rise) |=> pend[PB_OVR]);

  // R6
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (running && (ph == P_DRAIN) && cmd_ready) |=> (pend[PB_DONE] && !running));
endmodule

// File: tb/ufm_seq_tx_test.sv
module ufm_seq_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 64;
  localparam int BUF_DEPTH = 512;
  localparam int SW = 6;
  localparam int AW = 9;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, bit_en = 1'b0;
  logic start = 1'b0, loop_en = 1'b0, loop_trig = 1'b0, trig_in = 1'b0;
  logic [SW-1:0] last_slot = '0, st_slot = '0;
  logic [15:0] interval = '0;
  logic tbl_we = 1'b0;
  logic [1:0] tbl_sel = '0;
  logic [AW-1:0] tbl_addr = '0;
  logic [7:0] tbl_wdata = '0;
  logic [2:0] irq_mask = '0;
  logic irq_ack = 1'b0;
  logic [1:0] st_code;
  logic busy, irq, scl, sda;
  logic [2:0] irq_pend;

  int nchk = 0, nfail = 0, ackerr = 0;
  int mon_q[$];
  int exp_q[$];
  logic [6:0] m_adr [NSLOT];
  int         m_cnt [NSLOT];
  logic [7:0] m_buf [BUF_DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;
  always_ff @(posedge clk) bit_en <= ~bit_en;

  ufm_seq_tx uut (.clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bit_en(bit_en),
    .start(start), .last_slot(last_slot), .loop_en(loop_en), .loop_trig(loop_trig),
    .interval(interval), .trig_in(trig_in), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
    .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .st_slot(st_slot), .st_code(st_code),
    .irq_mask(irq_mask), .irq_ack(irq_ack), .busy(busy), .irq_pend(irq_pend),
    .irq(irq), .scl(scl), .sda(sda));

  // line decoder: -1 = START, -2 = STOP, else a byte
  logic pscl = 1'b1, psda = 1'b1;
  logic [7:0] sh = '0;
  int nb = 0;
  always @(negedge clk) begin
    if (pscl && scl && psda && !sda) begin mon_q.push_back(-1); nb = 0; end
    else if (pscl && scl && !psda && sda) begin mon_q.push_back(-2); nb = 0; end
    else if (!pscl && scl) begin
      if (nb < 8) sh = {sh[6:0], sda};
      nb++;
      if (nb == 9) begin
        if (!sda) ackerr++;
        mon_q.push_back(int'(sh)); nb = 0;
      end
    end
    pscl = scl; psda = sda;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int addr, input int data);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = 2'(sel); tbl_addr = AW'(addr); tbl_wdata = 8'(data);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic load_cfg(input int last, input int zero_pct);
    int p = 0;
    for (int i = 0; i <= last; i++) begin
      m_adr[i] = 7'($urandom % 128);
      m_cnt[i] = (($urandom % 100) < zero_pct) ? 0 : 1 + ($urandom % 4);
      wr(0, i, int'(m_adr[i]));
      wr(1, i, m_cnt[i]);
      p += m_cnt[i];
    end
    for (int j = 0; j < p; j++) begin
      m_buf[j] = 8'($urandom);
      wr(2, j, int'(m_buf[j]));
    end
  endtask

  function automatic void build_exp(input int last);
    int p = 0;
    bit any = 0;
    exp_q.delete();
    for (int i = 0; i <= last; i++) begin
      if (m_cnt[i] != 0) begin
        exp_q.push_back(-1);
        exp_q.push_back(int'({m_adr[i], 1'b0}));
        for (int k = 0; k < m_cnt[i]; k++) exp_q.push_back(int'(m_buf[p + k]));
        p += m_cnt[i];
        any = 1;
      end
    end
    if (any) exp_q.push_back(-2);
  endfunction

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 40000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic cmp_events(input string req);
    int bad = (mon_q.size() != exp_q.size()) ? 1 : 0;
    if (!bad) foreach (exp_q[i]) if (mon_q[i] != exp_q[i]) bad++;
    chk(bad == 0, req, mon_q.size(), exp_q.size());
  endtask

  task automatic check_status(input int last);
    int mism = 0;
    for (int i = 0; i <= last; i++) begin
      @(negedge clk); st_slot = SW'(i); #1;
      if (st_code != ((m_cnt[i] == 0) ? 2'd2 : 2'd1)) mism++;
    end
    chk(mism == 0, "R5 R6 slot status codes", mism, 0);
  endtask

  task automatic run_and_check(input int last, input string req);
    last_slot = SW'(last);
    build_exp(last);
    mon_q.delete();
    pulse_start();
    wait_idle();
    cmp_events(req);
  endtask

  bit finished = 0;

  initial begin
    void'($urandom(32'h5eed_0c1e));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(scl && sda, "R1 lines high after reset", {scl, sda}, 3);
    chk(!busy && !irq && irq_pend == 0, "R1 idle after reset", {busy, irq}, 0);

    // random sequences, directed full-length one
    for (int r = 0; r < 4; r++) begin
      int last = (r == 3) ? NSLOT - 1 : 1 + ($urandom % 12);
      load_cfg(last, 20);
      irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
      run_and_check(last, "R2 R3 R4 frame stream");
      check_status(last);
      chk(irq_pend[0], "R6 done flag", irq_pend[0], 1);
    end
    chk(ackerr == 0, "R2 ninth clock sda high", ackerr, 0);

    // zero-count slot in the middle; interrupt masking
    m_cnt[0] = 2; m_cnt[1] = 0; m_cnt[2] = 1;
    for (int i = 0; i < 3; i++) begin wr(0, i, int'(m_adr[i])); wr(1, i, m_cnt[i]); end
    for (int j = 0; j < 3; j++) wr(2, j, int'(m_buf[j]));
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    irq_mask = 3'b011;
    run_and_check(2, "R5 zero slot skipped, R3 repeated start");
    chk(irq_pend[1] && !irq, "R7 masked flags give no irq", {irq_pend, irq}, 4'b0110);
    irq_mask = 3'b000; @(negedge clk);
    chk(irq, "R7 unmasked flag raises irq", irq, 1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0; @(negedge clk);
    chk(!irq && irq_pend == 0, "R7 ack clears flags", irq_pend, 0);

    // all slots zero: no line activity
    for (int i = 0; i < 3; i++) begin m_cnt[i] = 0; wr(1, i, 0); end
    run_and_check(2, "R5 all-zero sequence leaves line quiet");

    // write while busy is ignored
    load_cfg(5, 0);
    last_slot = 5; mon_q.delete(); pulse_start();
    repeat (20) @(negedge clk);
    tbl_we = 1'b1; tbl_sel = 2'd2; tbl_addr = '0; tbl_wdata = ~m_buf[0];
    @(negedge clk);
    tbl_sel = 2'd0; tbl_wdata = 8'(~m_adr[0]);
    @(negedge clk); tbl_we = 1'b0;
    wait_idle();
    run_and_check(5, "R11 writes during pass ignored");

    // timer loop gap
    begin
      int gap = 0, n = 0;
      interval = 16'd7; loop_trig = 1'b0; loop_en = 1'b1;
      last_slot = 1; pulse_start();
      while (busy && n < 40000) begin @(negedge clk); n++; end
      while (!busy && gap < 1000) begin @(negedge clk); gap++; end
      chk(gap == 8, "R8 timer replay gap", gap, 8);
      loop_en = 1'b0;
      wait_idle();
      n = 0;
      repeat (200) begin @(negedge clk); if (busy) n++; end
      chk(n == 0, "R9 loop stops when disabled", n, 0);
    end

    // trigger loop
    begin
      int n = 0;
      loop_trig = 1'b1; loop_en = 1'b1;
      irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
      pulse_start(); wait_idle();
      repeat (300) begin @(negedge clk); if (busy) n++; end
      chk(n == 0, "R9 no replay without trigger edge", n, 0);
      trig_in = 1'b1; n = 0;
      while (!busy && n < 20) begin @(negedge clk); n++; end
      chk(busy, "R9 trigger edge starts replay", busy, 1);
      chk(irq_pend[2] == 1'b0, "R10 no overrun for a waiting trigger", irq_pend[2], 0);
      trig_in = 1'b0; repeat (6) @(negedge clk);
      trig_in = 1'b1; repeat (6) @(negedge clk);
      chk(irq_pend[2], "R10 overrun on trigger during pass", irq_pend[2], 1);
      loop_en = 1'b0; trig_in = 1'b0;
      wait_idle();
    end

    // soft reset mid frame
    load_cfg(8, 0);
    last_slot = 8; pulse_start();
    repeat (151) @(negedge clk);
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    st_slot = '0; #1;
    chk(scl && sda && !busy, "R12 soft reset idles the line", {scl, sda, busy}, 6);
    chk(irq_pend == 0 && st_code == 0, "R12 soft reset clears flags and status",
        {irq_pend, st_code}, 0);
    repeat (40) @(negedge clk);
    chk(scl && sda, "R1 R13 lines stay high after soft reset", {scl, sda}, 3);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule